// File: doc/BRIEF.md
# Gated-Clock Byte Packer and Serializer

This block takes bytes from a source that also supplies the clock for them. That source clock pulses only while bytes are being offered and is otherwise stopped. Every rising edge of the source clock captures one byte. Four of these bytes are packed into a 32-bit word. The finished word is parked in a single holding register, and the block signals that it is there by inverting a request toggle bit.

A second clock runs freely. In that clock's domain the toggle is synchronized, the held word is loaded into a shift register and sent out serially, most significant bit first. A valid strobe and a first-bit marker go with the serial data. The serial side returns an acknowledge toggle. The write side samples it again whenever its own clock runs.

Because both directions of the handshake are level toggles, no information is lost when the source clock stops right after a word is complete. A word that completes while the previous one is still unacknowledged is discarded and raises a sticky overflow flag.

Top module: `byte_pack_serializer`

## Requirements
- R1: One byte is taken from `wdata` on every rising edge of `wclk`. The first byte of a group of four lands in bits 31:24 of the word and the fourth byte lands in bits 7:0.
- R2: No serial output starts until all four bytes of a word have been captured. Fewer than four bytes produce no output, however long the serial clock runs.
- R3: A word is sent most significant bit first on `ser_data`, one bit per `sclk` cycle. `ser_valid` is high for exactly 32 consecutive cycles per word.
- R4: `ser_frame` is high only in the cycle that carries bit 31 of a word.
- R5: A completed word is delivered even if `wclk` stops indefinitely right after the fourth byte.
- R6: The holding register keeps the accepted word unchanged until the write side has seen the matching acknowledge. A word that is pending while a later word completes is still delivered intact.
- R7: A word that completes while a hand-off is still unacknowledged is dropped and never appears on the serial output. `wr_overflow` is then set to 1 and stays at 1 until `wrst_n` is asserted.
- R8: `wr_busy` reads 1 after the edge that accepts a word. It returns to 0 once two `wclk` edges have passed after the serial side acknowledged.
- R9: While reset is asserted, `ser_valid`, `wr_busy` and `wr_overflow` are 0. Both toggle bits come out of reset equal, so no transfer is pending.
- R10: A request that is seen while a word is still shifting waits for that word to finish. It is then loaded so that exactly one idle cycle (`ser_valid` low) separates the two words.
- R11: Both resets assert asynchronously. Each reset input is expected to be released synchronously to its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Source-driven byte clock; runs only while bytes are offered |
| wrst_n | input | 1 | Active-low reset of the write domain |
| wdata | input | 8 | Byte captured on each rising `wclk` edge |
| sclk | input | 1 | Free-running serial clock |
| srst_n | input | 1 | Active-low reset of the serial domain |
| ser_data | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | High while `ser_data` carries a word bit |
| ser_frame | output | 1 | High on the first bit of each word |
| wr_busy | output | 1 | Hand-off pending, in the write domain |
| wr_overflow | output | 1 | Sticky flag: a completed word was dropped |

## Verification
Two events can coincide. On the write side, a new word can complete while the hand-off is still pending. On the serial side, a request can arrive while the previous word is still shifting. The bench sets up both cases at once. It sends one word, waits until that word is shifting, and then sends two more words back to back. The second word is therefore accepted into the holding register while the first is still on the line, and the third completes while the second is still unacknowledged. The bench then checks the following: the overflow flag is set; exactly the first two words appear on the serial output, bit-exact; one idle cycle separates them; and a later word still gets through while the flag remains set.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int BPS_DATA_W      = 8;
  localparam int BPS_BYTES       = 4;
  localparam int BPS_SYNC_STAGES = 2;
endpackage

// File: rtl/bps_sync.sv
module bps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] stage_d;
    if (i == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bps_packer.sv
module bps_packer #(
  parameter int DATA_W      = 8,
  parameter int BYTES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DATA_W * BYTES
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_tgl,
  output logic [WORD_W-1:0] hold,
  output logic              req_tgl,
  output logic              busy,
  output logic              ovf
);
  localparam int ACC_W = WORD_W - DATA_W;
  localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              req_q, req_d;
  logic              ovf_q, ovf_d;
  logic              ack_s;
  logic              last, pending, accept;

  // acknowledge toggle only advances while wclk runs
  bps_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (wclk),
    .rst_n (wrst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  always_comb begin
    last    = (cnt_q == CNT_W'(BYTES - 1));
    pending = (req_q != ack_s);
    accept  = last && !pending;
    cnt_d   = last ? '0 : cnt_q + CNT_W'(1);
    acc_d   = ACC_W'({acc_q, wdata});
    hold_d  = accept ? {acc_q, wdata} : hold_q;
    req_d   = req_q ^ accept;
    ovf_d   = ovf_q | (last && pending);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      hold_q <= '0;
      req_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      hold_q <= hold_d;
      req_q  <= req_d;
      ovf_q  <= ovf_d;
    end
  end

  assign hold    = hold_q;
  assign req_tgl = req_q;
  assign busy    = pending;
  assign ovf     = ovf_q;

  // R6: held word frozen while its hand-off is outstanding
  a_r6_hold_stable: assert property (@(posedge wclk) disable iff (!wrst_n)
    pending |=> $stable(hold_q));
  // R7: completion during a pending hand-off raises overflow
  a_r7_drop_flags: assert property (@(posedge wclk) disable iff (!wrst_n)
    (last && pending) |=> ovf_q);
  // R7: overflow is sticky
  a_r7_ovf_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
    ovf_q |=> ovf_q);
  // R8: an accepted word leaves the hand-off pending
  a_r8_busy_after_accept: assert property (@(posedge wclk) disable iff (!wrst_n)
    accept |=> (req_q != ack_s));
endmodule

// File: rtl/bps_shifter.sv
module bps_shifter #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sclk,
  input  logic              srst_n,
  input  logic              req_tgl,
  input  logic [WORD_W-1:0] hold,
  output logic              ack_tgl,
  output logic              ser_data,
  output logic              ser_valid,
  output logic              ser_frame
);
  localparam int SCNT_W = $clog2(WORD_W);
  localparam logic [SCNT_W-1:0] LAST_BIT = SCNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [SCNT_W-1:0] cnt_q, cnt_d;
  logic              active_q, active_d;
  logic              seen_q, seen_d;
  logic              req_s, load, end_bit;

  bps_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (sclk),
    .rst_n (srst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  always_comb begin
    end_bit  = active_q && (cnt_q == LAST_BIT);
    load     = (req_s != seen_q) && !active_q;
    seen_d   = load ? req_s : seen_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    if (load) begin
      sh_d     = hold;
      cnt_d    = '0;
      active_d = 1'b1;
    end else if (active_q) begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      cnt_d = cnt_q + SCNT_W'(1);
      if (end_bit) active_d = 1'b0;
    end
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      seen_q   <= seen_d;
    end
  end

  assign ack_tgl   = seen_q;
  assign ser_data  = sh_q[WORD_W-1];
  assign ser_valid = active_q;
  assign ser_frame = active_q && (cnt_q == '0);

  // R3: valid holds through the word
  a_r3_valid_holds: assert property (@(posedge sclk) disable iff (!srst_n)
    (active_q && cnt_q != LAST_BIT) |=> active_q);
  // R3 / R10: valid drops after the last bit
  a_r10_gap_after_word: assert property (@(posedge sclk) disable iff (!srst_n)
    end_bit |=> !active_q);
  // R4: a word starts with the frame marker
  a_r4_frame_first: assert property (@(posedge sclk) disable iff (!srst_n)
    $rose(ser_valid) |-> ser_frame);
  // R5: acknowledge moves only when a word is loaded
  a_r5_ack_on_load: assert property (@(posedge sclk) disable iff (!srst_n)
    !$stable(seen_q) |-> $rose(active_q));
endmodule

// File: rtl/byte_pack_serializer.sv
module byte_pack_serializer
  import bps_pkg::*;
#(
  parameter int DATA_W      = BPS_DATA_W,
  parameter int BYTES       = BPS_BYTES,
  parameter int SYNC_STAGES = BPS_SYNC_STAGES
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sclk,
  input  logic              srst_n,
  output logic              ser_data,
  output logic              ser_valid,
  output logic              ser_frame,
  output logic              wr_busy,
  output logic              wr_overflow
);
  localparam int WORD_W = DATA_W * BYTES;

  logic [WORD_W-1:0] hold;
  logic              req_tgl, ack_tgl;

  bps_packer #(.DATA_W(DATA_W), .BYTES(BYTES), .SYNC_STAGES(SYNC_STAGES)) u_packer (
    .wclk    (wclk),
    .wrst_n  (wrst_n),
    .wdata   (wdata),
    .ack_tgl (ack_tgl),
    .hold    (hold),
    .req_tgl (req_tgl),
    .busy    (wr_busy),
    .ovf     (wr_overflow)
  );

  bps_shifter #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shifter (
    .sclk      (sclk),
    .srst_n    (srst_n),
    .req_tgl   (req_tgl),
    .hold      (hold),
    .ack_tgl   (ack_tgl),
    .ser_data  (ser_data),
    .ser_valid (ser_valid),
    .ser_frame (ser_frame)
  );

  // R9: reset leaves no transfer pending
  a_r9_reset_idle: assert property (@(posedge sclk) disable iff (!srst_n)
    $rose(srst_n) |-> !ser_valid);
endmodule

// File: tb/tb_byte_pack_serializer.sv
`timescale 1ns/1ps
module tb_byte_pack_serializer;
  logic       wclk, wrst_n, sclk, srst_n;
  logic [7:0] wdata;
  logic       ser_data, ser_valid, ser_frame, wr_busy, wr_overflow;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rx [0:31];
  int          rx_gap [0:31];
  bit          rx_frame_ok [0:31];
  int          n_rx = 0;
  int          run = 0, idle = 1000;
  logic [31:0] acc = '0;
  bit          frame_bad = 0, len_err = 0, just_done = 0;

  byte_pack_serializer dut (
    .wclk(wclk), .wrst_n(wrst_n), .wdata(wdata),
    .sclk(sclk), .srst_n(srst_n),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_frame(ser_frame),
    .wr_busy(wr_busy), .wr_overflow(wr_overflow)
  );

  initial sclk = 0;
  always #5 sclk = ~sclk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // serial monitor, samples away from the active edge
  always @(negedge sclk) begin
    if (srst_n) begin
      if (ser_valid) begin
        if (run == 0) begin
          if (just_done) len_err = 1;
          frame_bad = !ser_frame;
          rx_gap[n_rx] = idle;
        end else if (ser_frame) frame_bad = 1;
        acc = {acc[30:0], ser_data};
        run++;
        just_done = 0;
        if (run == 32) begin
          rx[n_rx] = acc;
          rx_frame_ok[n_rx] = !frame_bad;
          n_rx++;
          run = 0;
          idle = 0;
          just_done = 1;
        end
      end else begin
        if (run != 0) len_err = 1;
        run = 0;
        idle++;
        just_done = 0;
      end
    end
  end

  function automatic logic [7:0] pat_byte(input int w, input int k);
    if (w == 6) return 8'h00;
    if (w == 7) return 8'hFF;
    return 8'((w * 37 + k * 91 + 5) & 255);
  endfunction

  function automatic logic [31:0] pat_word(input int w);
    return {pat_byte(w, 0), pat_byte(w, 1), pat_byte(w, 2), pat_byte(w, 3)};
  endfunction

  task automatic send_byte(input logic [7:0] b);
    wdata = b;
    #10 wclk = 1;
    #10 wclk = 0;
  endtask

  // sends a word; optionally checks R8 busy behaviour around it
  task automatic send_word(input int w, input bit chk_busy);
    for (int k = 0; k < 4; k++) begin
      send_byte(pat_byte(w, k));
      if (chk_busy && k == 1) chk(wr_busy == 1'b0, "R8 busy clears after ack", 32'(wr_busy), 32'd0);
    end
    if (chk_busy) chk(wr_busy == 1'b1, "R8 busy after accept", 32'(wr_busy), 32'd1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_rx, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    wclk = 0; wdata = 8'h00; wrst_n = 0; srst_n = 0;
    repeat (3) @(posedge sclk);
    #2;
    // R9 / R11: outputs idle while reset is held
    chk(ser_valid == 0, "R9 reset ser_valid", 32'(ser_valid), 0);
    chk(wr_busy == 0, "R9 reset busy", 32'(wr_busy), 0);
    chk(wr_overflow == 0, "R11 reset overflow", 32'(wr_overflow), 0);
    @(negedge sclk); srst_n = 1; wrst_n = 1;
    repeat (10) @(negedge sclk);
    chk(n_rx == 0, "R9 no transfer after reset", 32'(n_rx), 0);

    // R2: three bytes alone produce nothing
    for (int k = 0; k < 3; k++) send_byte(pat_byte(0, k));
    repeat (60) @(negedge sclk);
    chk(n_rx == 0 && !ser_valid, "R2 partial word silent", 32'(n_rx), 0);
    send_byte(pat_byte(0, 3));
    chk(wr_busy == 1'b1, "R8 busy after accept", 32'(wr_busy), 1);
    repeat (45) @(negedge sclk);
    chk(n_rx == 1 && rx[0] == pat_word(0), "R1 byte order word 0", rx[0], pat_word(0));

    // R1 / R3 / R4 / R5: sweep with wclk stopped between words
    for (int w = 1; w <= 9; w++) begin
      send_word(w, 1);
      repeat (45) @(negedge sclk);
      chk(n_rx == w + 1, "R5 word delivered with clock stopped", 32'(n_rx), 32'(w + 1));
      chk(rx[w] == pat_word(w), "R3 serial bits MSB first", rx[w], pat_word(w));
      chk(rx_frame_ok[w], "R4 frame marker on first bit only", 32'(rx_frame_ok[w]), 1);
    end
    chk(wr_overflow == 0, "R7 no overflow in spaced traffic", 32'(wr_overflow), 0);

    // R6 / R7 / R10: collision of pending hand-off and shifting word
    base = n_rx;
    send_word(10, 0);
    repeat (8) @(negedge sclk);
    send_word(11, 0);
    send_word(12, 0);
    chk(wr_overflow == 1, "R7 overflow set on dropped word", 32'(wr_overflow), 1);
    repeat (120) @(negedge sclk);
    chk(n_rx == base + 2, "R7 dropped word not sent", 32'(n_rx), 32'(base + 2));
    chk(rx[base] == pat_word(10), "R6 first word intact", rx[base], pat_word(10));
    chk(rx[base + 1] == pat_word(11), "R6 held word intact", rx[base + 1], pat_word(11));
    chk(rx_gap[base + 1] == 1, "R10 one idle cycle between words", 32'(rx_gap[base + 1]), 1);

    // R7 sticky, traffic continues
    send_word(13, 0);
    repeat (45) @(negedge sclk);
    chk(rx[base + 2] == pat_word(13), "R7 later word delivered", rx[base + 2], pat_word(13));
    chk(wr_overflow == 1, "R7 overflow sticky", 32'(wr_overflow), 1);
    chk(!len_err, "R3 valid exactly 32 cycles", 32'(len_err), 0);

    // R11: write reset clears the sticky flag
    wrst_n = 0;
    #3;
    chk(wr_overflow == 0, "R11 async reset clears overflow", 32'(wr_overflow), 0);
    wrst_n = 1;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule